// File: doc/BRIEF.md
# Local Interrupt Pending and Priority Unit

This block keeps the machine-level and supervisor-level interrupt pending and enable state of one hart, together with the delegation register that routes supervisor-class interrupts to S-mode. Next to the usual external, software and timer sources it has a local counter-overflow interrupt at bit 13. A hardware request sets that bit and it stays set. Software can read and write it through the machine pending view and, once it is delegated, through the supervisor pending view.

Every cycle the unit looks at the pending, enabled and delegated interrupts and at the current privilege mode and global enables. It then names the single interrupt that the hart should take now, gives its cause as a bit index, and says whether the trap goes to M-mode or to S-mode. Trap entry itself is handled by the pipeline that uses these outputs.

Access to the registers goes through a simple select, write-strobe and write-data port. Reads are combinational from the registered state.

Top module: `lirq_ctrl`

## Requirements
- R1: After reset the pending, enable and delegation registers read as zero and no interrupt is selected (irq_valid_o = 0, irq_cause_o = 0, irq_to_s_o = 0).
- R2: A one-cycle pulse on ovf_set_i sets pending bit 13. The bit stays set until software writes it to zero. If the pulse and a software clear fall in the same cycle, the bit ends up set.
- R3: With csr_sel_i = 0 (machine pending view), writes change only bits 1, 5, 9 and 13. Bits 11, 3 and 7 follow m_ext_i, m_sw_i and m_tmr_i one clock later and ignore writes.
- R4: With csr_sel_i = 2 (supervisor pending view) or 3 (supervisor enable view), only the delegated bits are visible. Non-delegated bits read as zero and writes to them are ignored. csr_sel_i = 1 is the machine enable view, in which bits 1, 3, 5, 7, 9, 11 and 13 are writable.
- R5: With csr_sel_i = 4 the delegation register is accessed. Only bits 1, 5, 9 and 13 can be set; all other bits read as zero.
- R6: A pending, enabled, non-delegated interrupt is taken toward M-mode when priv_i (0 = U, 1 = S, 3 = M) is below M, or when m_gie_i is 1.
- R7: A pending, enabled, delegated interrupt is taken toward S-mode when priv_i is U, or when priv_i is S and s_gie_i is 1. It is never taken while priv_i is M.
- R8: When an M-targeted interrupt can be taken, it wins over any S-targeted one, whatever their bit positions.
- R9: Within one target mode the order from highest to lowest priority is bit 11, 3, 7, 9, 1, 5, 13.
- R10: irq_cause_o is the bit index of the selected interrupt, qualified by irq_valid_o. irq_to_s_o is 1 for an S-mode target. Both are 0 when nothing is selected.
- R11: With HAS_OVF = 0, bit 13 is tied to zero in the pending, enable and delegation registers, and ovf_set_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_ext_i | input | 1 | Machine external interrupt level |
| m_sw_i | input | 1 | Machine software interrupt level |
| m_tmr_i | input | 1 | Machine timer interrupt level |
| s_ext_set_i | input | 1 | Pulse that sets supervisor external pending |
| s_sw_set_i | input | 1 | Pulse that sets supervisor software pending |
| s_tmr_set_i | input | 1 | Pulse that sets supervisor timer pending |
| ovf_set_i | input | 1 | Pulse that sets counter-overflow pending |
| priv_i | input | 2 | Current privilege mode (0 U, 1 S, 3 M) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 3 | Register view select (0..4) |
| csr_wdata_i | input | 16 | Write data |
| csr_rdata_o | output | 16 | Read data of the selected view |
| irq_valid_o | output | 1 | An interrupt is selected |
| irq_cause_o | output | 4 | Bit index of the selected interrupt |
| irq_to_s_o | output | 1 | Selected interrupt targets S-mode |

## Verification
The assertions assume that priv_i only takes the codes 0, 1 and 3; code 2 is reserved and is never driven. They also assume that the overflow and supervisor set pulses are low while reset is asserted, so the stickiness check never sees a pulse that fell into reset. The stimulus sets privilege and global enables only between register writes and keeps every set input at zero during reset. Each selection case is built from a fresh write of the delegation, enable and pending views.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    localparam int IRQ_W = 16;
    localparam int IDX_W = $clog2(IRQ_W);

    localparam int B_SSI = 1;
    localparam int B_MSI = 3;
    localparam int B_STI = 5;
    localparam int B_MTI = 7;
    localparam int B_SEI = 9;
    localparam int B_MEI = 11;
    localparam int B_COF = 13;

    localparam int NPRIO = 7;
    // highest priority first
    localparam int PRIO_ORDER [NPRIO] = '{B_MEI, B_MSI, B_MTI, B_SEI, B_SSI, B_STI, B_COF};

    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_M = 2'd3;

    typedef enum logic [2:0] {
        SEL_MPEND = 3'd0,
        SEL_MENAB = 3'd1,
        SEL_SPEND = 3'd2,
        SEL_SENAB = 3'd3,
        SEL_DLG   = 3'd4
    } csr_sel_e;

    typedef struct packed {
        logic [IRQ_W-1:0] pend;
        logic [IRQ_W-1:0] ie;
        logic [IRQ_W-1:0] dlg;
    } lirq_regs_t;

    function automatic logic [IRQ_W-1:0] bitm(input int b);
        return IRQ_W'(1) << b;
    endfunction
endpackage

// File: rtl/lirq_state.sv
module lirq_state
    import lirq_pkg::*;
#(
    parameter bit HAS_OVF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_ext_i,
    input  logic             m_sw_i,
    input  logic             m_tmr_i,
    input  logic             s_ext_set_i,
    input  logic             s_sw_set_i,
    input  logic             s_tmr_set_i,
    input  logic             ovf_set_i,
    input  logic             csr_we_i,
    input  logic [2:0]       csr_sel_i,
    input  logic [IRQ_W-1:0] csr_wdata_i,
    output lirq_regs_t       regs_o
);
    localparam logic [IRQ_W-1:0] OVF_MASK = HAS_OVF ? bitm(B_COF) : '0;
    localparam logic [IRQ_W-1:0] SW_MASK  = bitm(B_SSI) | bitm(B_STI) | bitm(B_SEI) | OVF_MASK;
    localparam logic [IRQ_W-1:0] LVL_MASK = bitm(B_MSI) | bitm(B_MTI) | bitm(B_MEI);
    localparam logic [IRQ_W-1:0] IE_MASK  = SW_MASK | LVL_MASK;

    lirq_regs_t regs_d, regs_q;
    logic [IRQ_W-1:0] hw_set, lvl, wmask;

    always_comb begin
        regs_d = regs_q;
        hw_set = '0;
        hw_set[B_SEI] = s_ext_set_i;
        hw_set[B_SSI] = s_sw_set_i;
        hw_set[B_STI] = s_tmr_set_i;
        hw_set[B_COF] = ovf_set_i;
        hw_set = hw_set & SW_MASK;
        lvl = '0;
        lvl[B_MEI] = m_ext_i;
        lvl[B_MSI] = m_sw_i;
        lvl[B_MTI] = m_tmr_i;
        wmask = SW_MASK & regs_q.dlg;

        if (csr_we_i) begin
            case (csr_sel_e'(csr_sel_i))
                SEL_MPEND: regs_d.pend = (regs_q.pend & ~SW_MASK) | (csr_wdata_i & SW_MASK);
                SEL_MENAB: regs_d.ie   = csr_wdata_i & IE_MASK;
                SEL_SPEND: regs_d.pend = (regs_q.pend & ~wmask) | (csr_wdata_i & wmask);
                SEL_SENAB: regs_d.ie   = (regs_q.ie & ~regs_q.dlg) | (csr_wdata_i & regs_q.dlg);
                SEL_DLG:   regs_d.dlg  = csr_wdata_i & SW_MASK;
                default:   regs_d = regs_q;
            endcase
        end
        // hardware set wins over a same-cycle software clear
        regs_d.pend = (regs_d.pend & SW_MASK) | hw_set | lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/lirq_prio.sv
module lirq_prio
    import lirq_pkg::*;
(
    input  logic [IRQ_W-1:0] cand_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        hit_o = |cand_i;
        idx_o = '0;
        // walk lowest to highest so the highest priority overrides
        for (int k = NPRIO - 1; k >= 0; k--) begin
            if (cand_i[PRIO_ORDER[k]]) idx_o = IDX_W'(PRIO_ORDER[k]);
        end
    end
endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
    import lirq_pkg::*;
#(
    parameter bit HAS_OVF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_ext_i,
    input  logic             m_sw_i,
    input  logic             m_tmr_i,
    input  logic             s_ext_set_i,
    input  logic             s_sw_set_i,
    input  logic             s_tmr_set_i,
    input  logic             ovf_set_i,
    input  logic [1:0]       priv_i,
    input  logic             m_gie_i,
    input  logic             s_gie_i,
    input  logic             csr_we_i,
    input  logic [2:0]       csr_sel_i,
    input  logic [IRQ_W-1:0] csr_wdata_i,
    output logic [IRQ_W-1:0] csr_rdata_o,
    output logic             irq_valid_o,
    output logic [IDX_W-1:0] irq_cause_o,
    output logic             irq_to_s_o
);
    localparam int NTGT = 2; // 0: machine target, 1: supervisor target

    lirq_regs_t       regs;
    logic [IRQ_W-1:0] cand [NTGT];
    logic             hit  [NTGT];
    logic [IDX_W-1:0] idx  [NTGT];
    logic             m_take, s_take;

    lirq_state #(.HAS_OVF(HAS_OVF)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .m_ext_i     (m_ext_i),
        .m_sw_i      (m_sw_i),
        .m_tmr_i     (m_tmr_i),
        .s_ext_set_i (s_ext_set_i),
        .s_sw_set_i  (s_sw_set_i),
        .s_tmr_set_i (s_tmr_set_i),
        .ovf_set_i   (ovf_set_i),
        .csr_we_i    (csr_we_i),
        .csr_sel_i   (csr_sel_i),
        .csr_wdata_i (csr_wdata_i),
        .regs_o      (regs)
    );

    always_comb begin
        cand[0] = regs.pend & regs.ie & ~regs.dlg;
        cand[1] = regs.pend & regs.ie & regs.dlg;
    end

    for (genvar g = 0; g < NTGT; g++) begin : g_pick
        lirq_prio u_prio (
            .cand_i (cand[g]),
            .hit_o  (hit[g]),
            .idx_o  (idx[g])
        );
    end

    always_comb begin
        m_take = hit[0] && ((priv_i != PRV_M) || m_gie_i);
        s_take = hit[1] && ((priv_i == PRV_U) || ((priv_i == PRV_S) && s_gie_i));
        irq_valid_o = m_take || s_take;
        irq_to_s_o  = !m_take && s_take;
        irq_cause_o = m_take ? idx[0] : (s_take ? idx[1] : '0);
    end

    always_comb begin
        case (csr_sel_e'(csr_sel_i))
            SEL_MPEND: csr_rdata_o = regs.pend;
            SEL_MENAB: csr_rdata_o = regs.ie;
            SEL_SPEND: csr_rdata_o = regs.pend & regs.dlg;
            SEL_SENAB: csr_rdata_o = regs.ie & regs.dlg;
            SEL_DLG:   csr_rdata_o = regs.dlg;
            default:   csr_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk
    import lirq_pkg::*;
#(
    parameter bit HAS_OVF = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       priv_i,
    input logic             m_gie_i,
    input logic             m_ext_i,
    input logic             ovf_set_i,
    input logic             irq_valid_o,
    input logic [IDX_W-1:0] irq_cause_o,
    input logic             irq_to_s_o,
    input lirq_regs_t       regs
);
    AST_CAUSE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (regs.pend[irq_cause_o] && regs.ie[irq_cause_o])); // R10

    AST_S_NOT_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_to_s_o) |-> (priv_i != PRV_M)); // R7

    AST_M_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && !irq_to_s_o && (priv_i == PRV_M)) |-> m_gie_i); // R6

    AST_M_OUTRANKS_S: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_to_s_o)
        |-> !(((priv_i != PRV_M) || m_gie_i) && (|(regs.pend & regs.ie & ~regs.dlg)))); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_OVF && $past(rst_n) && $past(ovf_set_i)) |-> regs.pend[B_COF]); // R2

    AST_LVL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (regs.pend[B_MEI] == $past(m_ext_i))); // R3
endmodule

bind lirq_ctrl lirq_chk #(.HAS_OVF(HAS_OVF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv_i      (priv_i),
    .m_gie_i     (m_gie_i),
    .m_ext_i     (m_ext_i),
    .ovf_set_i   (ovf_set_i),
    .irq_valid_o (irq_valid_o),
    .irq_cause_o (irq_cause_o),
    .irq_to_s_o  (irq_to_s_o),
    .regs        (regs)
);

// File: tb/sim_lirq_ctrl.sv
`timescale 1ns/1ps
module sim_lirq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_ext, m_sw, m_tmr, s_ext_set, s_sw_set, s_tmr_set, ovf_set;
    logic [1:0] priv;
    logic m_gie, s_gie, we;
    logic [2:0] sel;
    logic [15:0] wdata, rdata0, rdata1;
    logic valid0, valid1, to_s0, to_s1;
    logic [3:0] cause0, cause1;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .m_ext_i(m_ext), .m_sw_i(m_sw), .m_tmr_i(m_tmr),
        .s_ext_set_i(s_ext_set), .s_sw_set_i(s_sw_set), .s_tmr_set_i(s_tmr_set),
        .ovf_set_i(ovf_set), .priv_i(priv), .m_gie_i(m_gie), .s_gie_i(s_gie),
        .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rdata0),
        .irq_valid_o(valid0), .irq_cause_o(cause0), .irq_to_s_o(to_s0)
    );

    lirq_ctrl #(.HAS_OVF(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .m_ext_i(m_ext), .m_sw_i(m_sw), .m_tmr_i(m_tmr),
        .s_ext_set_i(s_ext_set), .s_sw_set_i(s_sw_set), .s_tmr_set_i(s_tmr_set),
        .ovf_set_i(ovf_set), .priv_i(priv), .m_gie_i(m_gie), .s_gie_i(s_gie),
        .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rdata1),
        .irq_valid_o(valid1), .irq_cause_o(cause1), .irq_to_s_o(to_s1)
    );

    typedef struct packed {
        logic [2:0]  lvl;   // {ext, sw, tmr}
        logic [15:0] pnd;
        logic [15:0] ie;
        logic [15:0] dlg;
        logic [1:0]  prv;
        logic        mg;
        logic        sg;
        logic        ev;
        logic [3:0]  ec;
        logic        es;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'b111, 16'h2222, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd11, 1'b0}, // R9
        '{3'b011, 16'h2222, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd3,  1'b0}, // R9
        '{3'b001, 16'h2222, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd7,  1'b0}, // R9
        '{3'b000, 16'h2222, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd9,  1'b0}, // R9
        '{3'b000, 16'h2022, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd1,  1'b0}, // R9
        '{3'b000, 16'h2020, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd5,  1'b0}, // R9
        '{3'b000, 16'h2000, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd13, 1'b0}, // R10
        '{3'b000, 16'h2000, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0}, // R6
        '{3'b000, 16'h2000, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 4'd13, 1'b0}, // R6
        '{3'b000, 16'h2222, 16'hFFFF, 16'h2222, 2'd1, 1'b0, 1'b1, 1'b1, 4'd9,  1'b1}, // R7
        '{3'b000, 16'h2222, 16'hFFFF, 16'h2222, 2'd1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0}, // R7
        '{3'b000, 16'h2222, 16'hFFFF, 16'h2222, 2'd0, 1'b0, 1'b0, 1'b1, 4'd9,  1'b1}, // R7
        '{3'b000, 16'h2222, 16'hFFFF, 16'h2222, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0,  1'b0}, // R7
        '{3'b100, 16'h2222, 16'hFFFF, 16'h2222, 2'd1, 1'b0, 1'b1, 1'b1, 4'd11, 1'b0}, // R8
        '{3'b000, 16'h2002, 16'hFFFF, 16'h2000, 2'd1, 1'b0, 1'b1, 1'b1, 4'd1,  1'b0}, // R8
        '{3'b111, 16'h2222, 16'h0000, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0}, // R10
        '{3'b000, 16'h2020, 16'hFFFF, 16'h2020, 2'd1, 1'b0, 1'b1, 1'b1, 4'd5,  1'b1}  // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        sel = s; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic csr_rd0(input logic [2:0] s, output logic [15:0] d);
        sel = s;
        #1 d = rdata0;
    endtask

    task automatic csr_rd1(input logic [2:0] s, output logic [15:0] d);
        sel = s;
        #1 d = rdata1;
    endtask

    task automatic pulse_ovf();
        @(negedge clk);
        ovf_set = 1'b1;
        @(negedge clk);
        ovf_set = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        m_ext = 0; m_sw = 0; m_tmr = 0;
        s_ext_set = 0; s_sw_set = 0; s_tmr_set = 0; ovf_set = 0;
        priv = 2'd3; m_gie = 0; s_gie = 0; we = 0; sel = 3'd0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        csr_rd0(3'd0, rd); check("R1 mpend", 32'(rd), 32'h0);
        csr_rd0(3'd1, rd); check("R1 menab", 32'(rd), 32'h0);
        csr_rd0(3'd4, rd); check("R1 dlg",   32'(rd), 32'h0);
        check("R1 outputs", {valid0, cause0, to_s0}, 32'h0);

        // R2: overflow pulse sets bit 13 and it sticks
        pulse_ovf();
        csr_rd0(3'd0, rd); check("R2 set", 32'(rd), 32'h2000);
        repeat (3) @(negedge clk);
        csr_rd0(3'd0, rd); check("R2 sticky", 32'(rd), 32'h2000);
        csr_wr(3'd0, 16'h0000);
        csr_rd0(3'd0, rd); check("R2 cleared", 32'(rd), 32'h0);
        @(negedge clk);
        sel = 3'd0; wdata = 16'h0000; we = 1'b1; ovf_set = 1'b1;
        @(negedge clk);
        we = 1'b0; ovf_set = 1'b0;
        csr_rd0(3'd0, rd); check("R2 set beats clear", 32'(rd), 32'h2000);

        // R3: machine pending view write mask and level bits
        csr_wr(3'd0, 16'hFFFF);
        csr_rd0(3'd0, rd); check("R3 writable bits", 32'(rd), 32'h2222);
        m_ext = 1'b1;
        @(negedge clk);
        csr_rd0(3'd0, rd); check("R3 level follows", 32'(rd), 32'h2A22);
        csr_wr(3'd0, 16'h0000);
        csr_rd0(3'd0, rd); check("R3 level ignores write", 32'(rd), 32'h0800);
        m_ext = 1'b0;
        @(negedge clk);

        // R5: delegation mask
        csr_wr(3'd4, 16'hFFFF);
        csr_rd0(3'd4, rd); check("R5 dlg mask", 32'(rd), 32'h2222);

        // R4: supervisor views show only delegated bits
        csr_wr(3'd4, 16'h2000);
        csr_wr(3'd0, 16'h2222);
        csr_rd0(3'd2, rd); check("R4 spend view", 32'(rd), 32'h2000);
        csr_wr(3'd2, 16'h0000);
        csr_rd0(3'd0, rd); check("R4 spend clears only delegated", 32'(rd), 32'h0222);
        csr_wr(3'd2, 16'hFFFF);
        csr_rd0(3'd0, rd); check("R4 spend sets only delegated", 32'(rd), 32'h2222);
        csr_wr(3'd1, 16'h0000);
        csr_wr(3'd3, 16'hFFFF);
        csr_rd0(3'd1, rd); check("R4 senab reaches menab", 32'(rd), 32'h2000);
        csr_rd0(3'd3, rd); check("R4 senab view", 32'(rd), 32'h2000);
        csr_wr(3'd1, 16'hFFFF);
        csr_rd0(3'd1, rd); check("R4 menab mask", 32'(rd), 32'h2AAA);

        // R11: variant without the overflow interrupt
        pulse_ovf();
        csr_wr(3'd4, 16'hFFFF);
        csr_wr(3'd0, 16'hFFFF);
        csr_wr(3'd1, 16'hFFFF);
        csr_rd1(3'd0, rd); check("R11 pend bit13 tied", 32'(rd), 32'h0222);
        csr_rd1(3'd1, rd); check("R11 enab bit13 tied", 32'(rd), 32'h0AAA);
        csr_rd1(3'd4, rd); check("R11 dlg bit13 tied", 32'(rd), 32'h0222);

        // R6..R10: selection table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {m_ext, m_sw, m_tmr} = VECS[i].lvl;
            csr_wr(3'd4, VECS[i].dlg);
            csr_wr(3'd1, VECS[i].ie);
            csr_wr(3'd0, VECS[i].pnd);
            priv = VECS[i].prv; m_gie = VECS[i].mg; s_gie = VECS[i].sg;
            #1;
            check($sformatf("R6-R10 sel vec %0d (R9 order, R8 rank, R7 S gate, R6 M gate, R10 cause)", i),
                  {valid0, cause0, to_s0}, {VECS[i].ev, VECS[i].ec, VECS[i].es});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule